// File: doc/BRIEF.md
# Conversion-Complete Interrupt Router

This block takes the sixteen end-of-conversion pulses of a shared converter subsystem and routes them onto eight interrupt lines. Each line has its own 4-bit source index, so any line can follow any pulse. When the chosen pulse arrives, the line always raises a sticky flag. If the line is enabled, it also sends a one-cycle pulse to the downstream interrupt logic. Software clears flags by writing ones to a clear register. A per-line hold bit can block further pulses while that line's flag is still pending.

Lines 0 and 1 can also be fed back as start triggers for conversion slots. Each of the sixteen slots has a 2-bit setting that picks no feedback, line 0 or line 1. The trigger is registered, so a completion can start the next conversion without a combinational loop. This lets the converter run a self-sustaining chain. All converter instances share one set of lines.

Each line is a two-state machine. It sits in `LN_IDLE` while its flag is clear. Transition `T_SET` goes `LN_IDLE`→`LN_PENDING` when the selected pulse arrives. Transition `T_CLEAR` goes `LN_PENDING`→`LN_IDLE` when a clear is written and no selected pulse arrives in the same cycle. Transition `T_STAY` keeps a line in its current state in every other case.

Top module: `eoc_irq_router`

## Requirements
- R1: After reset, every line has source 0, enable 0 and hold 0. Feedback enables are 0, and all flags, interrupt outputs and slot triggers are 0.
- R2: Line i raises `irq_flag[i]` one cycle after `eoc[src_i]` is high. Pulses on other inputs leave it unchanged. Config register i (address i, 0..7) holds the source in bits [3:0], the enable in bit 4 and the hold in bit 5. A write takes effect from the next cycle.
- R3: A flag stays set until a write to address 8 with a 1 in bit i clears it one cycle later. Zero bits in that write leave their flags unchanged.
- R4: If line i's selected pulse and a clear of bit i happen in the same cycle, the flag is set afterwards.
- R5: `irq_out[i]` is high for exactly the cycle after a selected pulse when the line is enabled. A disabled line still sets its flag but keeps `irq_out[i]` low.
- R6: If line i's hold bit is 1 and its flag is already set when a selected pulse arrives, no output pulse is made and the flag stays set.
- R7: Address 9 bits [1:0] enable feedback for lines 0 and 1. A slot fed by an enabled line asserts `slot_trig` one cycle after that line's selected pulse. This happens whatever the line's interrupt enable, hold or flag.
- R8: `slot_fb_sel[2s+1:2s]` picks the trigger source of slot s: 0 = none, 1 = line 0, 2 = line 1, 3 = none.
- R9: A write to any address from 10 to 15 changes no state.
- R10: Several lines may select the same source, and each reacts to it independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc | input | 16 | End-of-conversion pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| slot_fb_sel | input | 32 | Per-slot feedback select, 2 bits per slot |
| irq_out | output | 8 | One-cycle interrupt pulses |
| irq_flag | output | 8 | Sticky interrupt flags |
| slot_trig | output | 16 | Registered feedback triggers to slots |

## Verification
The bench targets these corner cases:

- **Set and clear in the same cycle.** A design that lets the clear win would lose an event.
- **Hold with a pending flag.** A design that ignores hold would send duplicate interrupts. One that drops the flag would lose the pending state.
- **Feedback on a disabled, held line.** A design that gates feedback with the interrupt enable would break the conversion chain.
- **Reserved select code 3 and unmapped addresses.** A wrong decode would make spurious triggers or corrupt the configuration.

Random traffic mixes pulses, writes and select changes. It finds cases where a config write lands in the same cycle as a pulse, which catches a design that applies the new source one cycle early.

// File: rtl/eoc_irq_router_pkg.sv
package eoc_irq_router_pkg;

    localparam int unsigned EOC_COUNT = 16;
    localparam int unsigned SRC_W     = $clog2(EOC_COUNT);
    localparam int unsigned FB_LINES  = 2;
    localparam int unsigned FB_SEL_W  = 2;

    typedef enum logic {
        LN_IDLE    = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

    typedef enum logic [FB_SEL_W-1:0] {
        FB_NONE  = 2'd0,
        FB_LINE0 = 2'd1,
        FB_LINE1 = 2'd2,
        FB_RSVD  = 2'd3
    } fb_sel_e;

    typedef struct packed {
        logic             hold;
        logic             en;
        logic [SRC_W-1:0] src;
    } line_cfg_t;

endpackage

// File: rtl/eoc_irq_router_regs.sv
module eoc_irq_router_regs
    import eoc_irq_router_pkg::*;
#(
    parameter int unsigned N_INT  = 8,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output line_cfg_t [N_INT-1:0]     cfg,
    output logic [N_INT-1:0]          clr,
    output logic [FB_LINES-1:0]       fb_en
);

    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(N_INT);
    localparam logic [ADDR_W-1:0] FB_ADDR  = ADDR_W'(N_INT + 1);

    logic clr_hit;
    logic fb_hit;

    assign clr_hit = wr_en && (wr_addr == CLR_ADDR);
    assign fb_hit  = wr_en && (wr_addr == FB_ADDR);

    // Clear strobes act in the same cycle as the write
    always_comb begin
        clr = '0;
        if (clr_hit) begin
            clr = wr_data[N_INT-1:0];
        end
    end

    // Per-line configuration registers
    for (genvar g = 0; g < N_INT; g++) begin : g_cfg
        logic cfg_hit;
        assign cfg_hit = wr_en && (wr_addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (cfg_hit) begin
                cfg[g].src  <= wr_data[SRC_W-1:0];
                cfg[g].en   <= wr_data[SRC_W];
                cfg[g].hold <= wr_data[SRC_W+1];
            end
        end
    end

    // Feedback enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_en <= '0;
        end else if (fb_hit) begin
            fb_en <= wr_data[FB_LINES-1:0];
        end
    end

endmodule

// File: rtl/eoc_irq_router_line.sv
module eoc_irq_router_line
    import eoc_irq_router_pkg::*;
#(
    parameter int unsigned N_EOC = EOC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EOC-1:0] eoc,
    input  line_cfg_t        cfg,
    input  logic             clr,
    output logic             evt,
    output logic             irq,
    output logic             flag
);

    line_state_e state_q;
    line_state_e state_d;

    // Selected completion pulse for this line
    assign evt = eoc[cfg.src];

    // Next-state logic: T_SET, T_CLEAR, T_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (evt) begin
                    state_d = LN_PENDING;
                end
            end
            LN_PENDING: begin
                if (clr && !evt) begin
                    state_d = LN_IDLE;
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: pulse unless held back by a pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= evt && cfg.en && !(cfg.hold && (state_q == LN_PENDING));
        end
    end

    assign flag = (state_q == LN_PENDING);

endmodule

// File: rtl/eoc_irq_router_fbmux.sv
module eoc_irq_router_fbmux
    import eoc_irq_router_pkg::*;
#(
    parameter int unsigned N_SLOT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [FB_SEL_W*N_SLOT-1:0]   fb_sel,
    input  logic [FB_LINES-1:0]          line_evt,
    input  logic [FB_LINES-1:0]          fb_en,
    output logic [N_SLOT-1:0]            slot_trig
);

    logic [FB_LINES-1:0] fb_src;

    assign fb_src = line_evt & fb_en;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        fb_sel_e sel;
        logic    trig_d;

        assign sel = fb_sel_e'(fb_sel[FB_SEL_W*s +: FB_SEL_W]);

        always_comb begin
            unique case (sel)
                FB_LINE0: trig_d = fb_src[0];
                FB_LINE1: trig_d = fb_src[1];
                FB_NONE,
                FB_RSVD:  trig_d = 1'b0;
                default:  trig_d = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_trig[s] <= 1'b0;
            end else begin
                slot_trig[s] <= trig_d;
            end
        end
    end

endmodule

// File: rtl/eoc_irq_router.sv
module eoc_irq_router
    import eoc_irq_router_pkg::*;
#(
    parameter int unsigned N_EOC  = EOC_COUNT,
    parameter int unsigned N_INT  = 8,
    parameter int unsigned N_SLOT = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = $clog2(N_INT + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_EOC-1:0]           eoc,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [FB_SEL_W*N_SLOT-1:0] slot_fb_sel,
    output logic [N_INT-1:0]           irq_out,
    output logic [N_INT-1:0]           irq_flag,
    output logic [N_SLOT-1:0]          slot_trig
);

    line_cfg_t [N_INT-1:0]  cfg;
    logic [N_INT-1:0]       clr;
    logic [FB_LINES-1:0]    fb_en;
    logic [N_INT-1:0]       line_evt;

    eoc_irq_router_regs #(
        .N_INT  (N_INT),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .clr     (clr),
        .fb_en   (fb_en)
    );

    for (genvar i = 0; i < N_INT; i++) begin : g_line
        eoc_irq_router_line #(
            .N_EOC (N_EOC)
        ) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .eoc   (eoc),
            .cfg   (cfg[i]),
            .clr   (clr[i]),
            .evt   (line_evt[i]),
            .irq   (irq_out[i]),
            .flag  (irq_flag[i])
        );
    end

    eoc_irq_router_fbmux #(
        .N_SLOT (N_SLOT)
    ) u_fbmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_sel    (slot_fb_sel),
        .line_evt  (line_evt[FB_LINES-1:0]),
        .fb_en     (fb_en),
        .slot_trig (slot_trig)
    );

endmodule

// File: rtl/eoc_irq_router_chk.sv
module eoc_irq_router_chk
    import eoc_irq_router_pkg::*;
#(
    parameter int unsigned N_EOC  = EOC_COUNT,
    parameter int unsigned N_INT  = 8,
    parameter int unsigned N_SLOT = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_EOC-1:0]           eoc,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [FB_SEL_W*N_SLOT-1:0] slot_fb_sel,
    input logic [N_INT-1:0]           irq_out,
    input logic [N_INT-1:0]           irq_flag,
    input logic [N_SLOT-1:0]          slot_trig
);

    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(N_INT);

    // No completion pulse: no interrupt pulse and no new flag next cycle
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc == '0) |=> ((irq_out == '0) && ((irq_flag & ~$past(irq_flag)) == '0)));

    for (genvar i = 0; i < N_INT; i++) begin : g_line_chk
        assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[i] && !(wr_en && (wr_addr == CLR_ADDR) && wr_data[i])) |=> irq_flag[i]);

        assert_pulse_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[i] |-> irq_flag[i]);
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot_chk
        assert_trig_from_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_trig[s] |-> (irq_flag[0] || irq_flag[1]));

        assert_sel_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((slot_fb_sel[FB_SEL_W*s +: FB_SEL_W] == 2'd0) ||
             (slot_fb_sel[FB_SEL_W*s +: FB_SEL_W] == 2'd3)) |=> !slot_trig[s]);
    end

endmodule

bind eoc_irq_router eoc_irq_router_chk #(
    .N_EOC  (N_EOC),
    .N_INT  (N_INT),
    .N_SLOT (N_SLOT),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoc         (eoc),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .slot_fb_sel (slot_fb_sel),
    .irq_out     (irq_out),
    .irq_flag    (irq_flag),
    .slot_trig   (slot_trig)
);

// File: tb/eoc_irq_router_test.sv
`timescale 1ns/1ps
module eoc_irq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] eoc = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] slot_fb_sel = '0;
    logic [7:0]  irq_out;
    logic [7:0]  irq_flag;
    logic [15:0] slot_trig;

    int total = 0;
    int bad = 0;

    // Reference model state
    int   m_src [8];
    bit   m_en  [8];
    bit   m_hold[8];
    bit   m_flag[8];
    bit   m_fb  [2];

    always #2 clk = ~clk;

    eoc_irq_router uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoc         (eoc),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .slot_fb_sel (slot_fb_sel),
        .irq_out     (irq_out),
        .irq_flag    (irq_flag),
        .slot_trig   (slot_trig)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] flags_vec();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = m_flag[i];
        return v;
    endfunction

    // One clock: drive inputs, predict, advance, compare
    task automatic step(input logic [15:0] e, input bit we, input logic [3:0] a,
                        input logic [7:0] d, input string tag);
        logic [7:0]  x_irq;
        logic [15:0] x_trig;
        bit          evt [8];
        eoc = e; wr_en = we; wr_addr = a; wr_data = d;
        for (int i = 0; i < 8; i++) begin
            bit clr;
            evt[i]   = e[m_src[i]];
            x_irq[i] = evt[i] && m_en[i] && !(m_hold[i] && m_flag[i]);
            clr      = we && (a == 4'd8) && d[i];
            m_flag[i] = evt[i] || (m_flag[i] && !clr);
        end
        for (int s = 0; s < 16; s++) begin
            logic [1:0] sel;
            sel = slot_fb_sel[2*s +: 2];
            x_trig[s] = (sel == 2'd1) ? (evt[0] && m_fb[0]) :
                        (sel == 2'd2) ? (evt[1] && m_fb[1]) : 1'b0;
        end
        if (we && a < 4'd8) begin
            m_src[a]  = int'(d[3:0]);
            m_en[a]   = d[4];
            m_hold[a] = d[5];
        end else if (we && a == 4'd9) begin
            m_fb[0] = d[0];
            m_fb[1] = d[1];
        end
        @(posedge clk);
        @(negedge clk);
        eoc = '0; wr_en = 1'b0;
        check(tag, "irq_out",   32'(irq_out),   32'(x_irq));
        check(tag, "irq_flag",  32'(irq_flag),  32'(flags_vec()));
        check(tag, "slot_trig", 32'(slot_trig), 32'(x_trig));
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        step('0, 1'b1, a, d, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_src[i] = 0; m_en[i] = 0; m_hold[i] = 0; m_flag[i] = 0;
        end
        m_fb[0] = 0; m_fb[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        check("R1", "irq_out",   32'(irq_out),   32'h0);
        check("R1", "irq_flag",  32'(irq_flag),  32'h0);
        check("R1", "slot_trig", 32'(slot_trig), 32'h0);
        // R1: default source 0, disabled: eoc[0] flags all lines, no pulses
        step(16'h0001, 0, 0, 0, "R1");
        wr(4'd8, 8'hFF, "R3");
        // R2: line 3 source 5, enabled
        wr(4'd3, 8'h15, "R2");
        step(16'h0040, 0, 0, 0, "R2");
        step(16'h0020, 0, 0, 0, "R2");
        // R3: clear other bits leaves flag 3, then clear it
        wr(4'd8, 8'hF7, "R3");
        wr(4'd8, 8'h08, "R3");
        // R4: set and clear in the same cycle
        step(16'h0020, 0, 0, 0, "R4");
        step(16'h0020, 1, 4'd8, 8'h08, "R4");
        // R5: disabled line flags without pulse
        wr(4'd2, 8'h05, "R5");
        step(16'h0020, 0, 0, 0, "R5");
        wr(4'd8, 8'hFF, "R5");
        // R6: hold suppresses repeat pulse while pending
        wr(4'd3, 8'h35, "R6");
        step(16'h0020, 0, 0, 0, "R6");
        step(16'h0020, 0, 0, 0, "R6");
        step(16'h0020, 1, 4'd8, 8'h08, "R6");
        wr(4'd8, 8'h08, "R6");
        step(16'h0020, 0, 0, 0, "R6");
        // R7/R8: feedback on a disabled, held, pending line 0
        slot_fb_sel = {8{2'd3, 2'd0, 2'd2, 2'd1}};
        wr(4'd0, 8'h22, "R7");
        wr(4'd1, 8'h17, "R7");
        wr(4'd9, 8'h03, "R7");
        step(16'h0004, 0, 0, 0, "R7");
        step(16'h0004, 0, 0, 0, "R7");
        step(16'h0080, 0, 0, 0, "R8");
        step(16'h0084, 0, 0, 0, "R8");
        wr(4'd9, 8'h02, "R7");
        step(16'h0084, 0, 0, 0, "R7");
        // R9: unmapped addresses change nothing
        for (int a = 10; a < 16; a++) wr(4'(a), 8'($urandom), "R9");
        step(16'h00A4, 0, 0, 0, "R9");
        wr(4'd8, 8'hFF, "R9");
        step(16'h0020, 0, 0, 0, "R9");
        // R10: two lines share one source
        wr(4'd4, 8'h19, "R10");
        wr(4'd5, 8'h29, "R10");
        step(16'h0200, 0, 0, 0, "R10");
        step(16'h0200, 0, 0, 0, "R10");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] e;
            bit          we;
            logic [3:0]  a;
            e  = 16'($urandom) & 16'($urandom);
            we = ($urandom % 10) < 3;
            a  = 4'($urandom % 16);
            if (($urandom % 50) == 0) slot_fb_sel = $urandom;
            step(e, we, a, 8'($urandom), "R2/R3/R4/R5/R6/R7");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule